// File: doc/BRIEF.md
# SPI Boot Image Loader with Shared Activity LEDs

After reset this block copies a firmware image out of an external SPI serial EEPROM or flash. It opens one chip-select window. In that window it sends a single read command and a start address of zero, then clocks in the number of bytes set by the image-length input. Each byte it receives goes out on a one-cycle write strobe, together with its byte address, so that downstream memory can store it. When the last byte has gone out, chip select returns high and a sticky done flag rises. No further serial transfers take place after that.

Once loading is over, two of the four serial pins are free. When four-LED mode is enabled, the serial-out pin and the serial-clock pin become active-low activity lamps for channel 3 and channel 2. Each channel's activity pulse is stretched to a parameterised number of cycles so that the lamp stays lit long enough to be seen.

Top module: `spi_boot_loader`

## Requirements
- R1: While reset is held, chip select is high, the serial clock is low, done is low and the write strobe is low.
- R2: The first 32 bits shifted out on the serial-out pin are the read opcode 0x03 followed by a 24-bit address of zero, most significant bit first. The ROM captures each bit on the rising edge of the serial clock.
- R3: While chip select is low, the serial-out pin changes only in a cycle where the serial clock is low both before and after the change.
- R4: While chip select is low, the serial clock has a period of CLK_DIV system cycles and stays high for CLK_DIV/2 of them. The serial clock is low whenever chip select is high before done.
- R5: The block samples serial-in on each rising edge of the serial clock and assembles data bytes MSB first. Each byte appears as a one-cycle wr_valid pulse, with wr_data, and with wr_addr counting up from 0 by one per byte.
- R6: Exactly img_len bytes are read in one chip-select window. Chip select goes high and done rises in the cycle after the final wr_valid pulse. Done then stays set, and chip select stays high until reset.
- R7: An img_len of 0, sampled when reset is released, sets done without ever driving chip select low.
- R8: After done, with chip select high and led_mode_en at 1, the serial-out pin is low while channel 3 is lit and the serial-clock pin is low while channel 2 is lit. Each pin is high otherwise.
- R9: A one-cycle pulse on act_pulse[i] lights that channel for exactly STRETCH cycles, starting the cycle after the pulse. A new pulse while the channel is lit starts the full count again.
- R10: Activity pulses have no effect on the pins before done. With led_mode_en at 0 after done, the serial clock and serial-out pins stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| img_len | input | 18 | Image length in bytes (0 to 131072), sampled when reset is released |
| led_mode_en | input | 1 | Enables four-LED mode after loading |
| act_pulse | input | 2 | Activity pulses: bit 0 is channel 2, bit 1 is channel 3 |
| spi_miso | input | 1 | Serial data from the ROM |
| spi_mosi | output | 1 | Serial data to the ROM; channel 3 lamp (active low) in LED mode |
| spi_sclk | output | 1 | Serial clock; channel 2 lamp (active low) in LED mode |
| spi_cs_n | output | 1 | Active-low chip select |
| wr_valid | output | 1 | One-cycle strobe for a received byte |
| wr_addr | output | 17 | Byte address of wr_data |
| wr_data | output | 8 | Received byte |
| done | output | 1 | Image fully read; sticky until reset |

## Verification
A wrong header shift register or bit counter shows up on the serial-out pin within the first 32 serial clock periods, as a header that differs from 0x03 and zero. A receive or byte-count fault shows up at the write port within one byte time, as a wrong wr_data for the given address or as an address that skips. A wrong length compare appears at the end of the image, as a byte count that differs from img_len or as a done flag that is not exactly one cycle after the final strobe. A fault in the pin multiplexer or the stretch counter is seen within one stretch interval, as a lamp that lights too early, too late or before loading has finished.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;

  localparam logic [7:0] RD_OPCODE = 8'h03;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_HDR,
    LD_DATA,
    LD_FINISH,
    LD_DONE
  } ld_state_t;

  // 32-bit header: opcode then a 24-bit byte address, upper bits zero
  function automatic logic [31:0] read_header(input logic [16:0] start_addr);
    return {RD_OPCODE, 7'd0, start_addr};
  endfunction

  // MSB-first byte assembly
  function automatic logic [7:0] shift_in(input logic [7:0] acc, input logic b);
    return {acc[6:0], b};
  endfunction

endpackage

// File: rtl/spi_bit_clock.sv
module spi_bit_clock #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ev_setup,
  output logic ev_rise,
  output logic ev_fall,
  output logic sclk
);
  localparam int HALF = CLK_DIV / 2;
  localparam int PH_W = $clog2(CLK_DIV);

  logic [PH_W-1:0] ph;

  assign ev_setup = run && (ph == PH_W'(0));
  assign ev_rise  = run && (ph == PH_W'(HALF - 1));
  assign ev_fall  = run && (ph == PH_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      ph   <= '0;
      sclk <= 1'b0;
    end else begin
      ph <= ev_fall ? '0 : ph + PH_W'(1);
      if (ev_rise) sclk <= 1'b1;
      else if (ev_fall) sclk <= 1'b0;
    end
  end

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);

endmodule

// File: rtl/spi_read_seq.sv
module spi_read_seq
  import boot_ld_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W:0]   img_len,
  input  logic              miso,
  input  logic              ev_setup,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              sclk,
  output logic              run,
  output logic              mosi,
  output logic              cs_n,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done
);
  localparam int LEN_W = ADDR_W + 1;

  ld_state_t        state;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] byte_cnt;
  logic [4:0]       bitn;
  logic [31:0]      txsr;
  logic [7:0]       rxsr;
  logic             last_byte;

  assign run       = (state == LD_HDR) || (state == LD_DATA);
  assign last_byte = (byte_cnt == len_q - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LD_IDLE;
      len_q    <= '0;
      byte_cnt <= '0;
      bitn     <= '0;
      txsr     <= '0;
      rxsr     <= '0;
      mosi     <= 1'b0;
      cs_n     <= 1'b1;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      unique case (state)
        LD_IDLE: begin
          len_q <= img_len;
          if (img_len == '0) begin
            state <= LD_FINISH;
          end else begin
            cs_n     <= 1'b0;
            txsr     <= read_header('0);
            bitn     <= '0;
            byte_cnt <= '0;
            state    <= LD_HDR;
          end
        end
        LD_HDR: begin
          if (ev_setup) begin
            mosi <= txsr[31];
            txsr <= {txsr[30:0], 1'b0};
          end
          if (ev_fall) begin
            if (bitn == 5'd31) begin
              bitn  <= '0;
              state <= LD_DATA;
            end else begin
              bitn <= bitn + 5'd1;
            end
          end
        end
        LD_DATA: begin
          if (ev_setup) mosi <= 1'b0;
          if (ev_rise) rxsr <= shift_in(rxsr, miso);
          if (ev_fall) begin
            if (bitn == 5'd7) begin
              bitn     <= '0;
              wr_valid <= 1'b1;
              wr_data  <= rxsr;
              wr_addr  <= byte_cnt[ADDR_W-1:0];
              byte_cnt <= byte_cnt + LEN_W'(1);
              if (last_byte) state <= LD_FINISH;
            end else begin
              bitn <= bitn + 5'd1;
            end
          end
        end
        LD_FINISH: begin
          cs_n  <= 1'b1;
          mosi  <= 1'b0;
          done  <= 1'b1;
          state <= LD_DONE;
        end
        default: ;
      endcase
    end
  end

  assert_mosi_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && (mosi != $past(mosi))) |-> (!sclk && !$past(sclk)));

  assert_wr_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !cs_n);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && cs_n));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (len_q == '0 || $past(wr_valid)));

endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int NCH     = 2,
  parameter int STRETCH = 2_000_000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pulse,
  output logic [NCH-1:0] lit
);
  localparam int CW = $clog2(STRETCH + 1);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (pulse[i])      cnt <= CW'(STRETCH);
      else if (cnt != '0)     cnt <= cnt - CW'(1);
    end

    assign lit[i] = (cnt != '0);

    assert_pulse_lights_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |=> lit[i]);
  end

endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader #(
  parameter int CLK_DIV = 8,
  parameter int STRETCH = 2_000_000,
  parameter int ADDR_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W:0]   img_len,
  input  logic              led_mode_en,
  input  logic [1:0]        act_pulse,
  input  logic              spi_miso,
  output logic              spi_mosi,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done
);
  localparam int NLED = 2;

  logic            run, ev_setup, ev_rise, ev_fall, sclk_q, mosi_q;
  logic [NLED-1:0] lit;
  logic            led_mode;

  spi_bit_clock #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ev_setup(ev_setup), .ev_rise(ev_rise), .ev_fall(ev_fall), .sclk(sclk_q)
  );

  spi_read_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .img_len(img_len), .miso(spi_miso),
    .ev_setup(ev_setup), .ev_rise(ev_rise), .ev_fall(ev_fall), .sclk(sclk_q),
    .run(run), .mosi(mosi_q), .cs_n(spi_cs_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  led_stretch #(.NCH(NLED), .STRETCH(STRETCH)) u_led (
    .clk(clk), .rst_n(rst_n), .pulse(act_pulse), .lit(lit)
  );

  // bit 0 = channel 2 (clock pin), bit 1 = channel 3 (data-out pin)
  assign led_mode = led_mode_en && done && spi_cs_n;
  assign spi_sclk = led_mode ? ~lit[0] : sclk_q;
  assign spi_mosi = led_mode ? ~lit[1] : mosi_q;

  assert_pins_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && spi_cs_n) |-> (!spi_sclk && !spi_mosi));

  assert_cs_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> spi_cs_n);

endmodule

// File: tb/sim_spi_boot_loader.sv
`timescale 1ns/1ps
module sim_spi_boot_loader;
  localparam int DIV = 6;
  localparam int STR = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] img_len = '0;
  logic        led_mode_en = 1'b0;
  logic [1:0]  act_pulse = '0;
  logic        spi_miso = 1'b0;
  logic        spi_mosi, spi_sclk, spi_cs_n, wr_valid, done;
  logic [16:0] wr_addr;
  logic [7:0]  wr_data;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  spi_boot_loader #(.CLK_DIV(DIV), .STRETCH(STR)) u0 (
    .clk(clk), .rst_n(rst_n), .img_len(img_len), .led_mode_en(led_mode_en),
    .act_pulse(act_pulse), .spi_miso(spi_miso), .spi_mosi(spi_mosi),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  function automatic logic [7:0] pat(input int a);
    logic [16:0] x;
    x = 17'(a);
    return (x[7:0] * 8'd37) ^ x[15:8] ^ {7'd0, x[16]} ^ 8'hA5;
  endfunction

  // ROM model: captures on sclk rise, drives on sclk fall
  int          rbits = 0;
  logic [31:0] hdr = '0;
  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) rbits = 0;
    else begin
      if (rbits < 32) hdr = {hdr[30:0], spi_mosi};
      rbits = rbits + 1;
    end
  end
  always @(negedge spi_sclk) begin
    if (!spi_cs_n && rbits >= 32) begin
      automatic int idx = rbits - 32;
      automatic logic [7:0] b = pat(idx / 8);
      spi_miso = b[7 - (idx % 8)];
    end
  end

  // port monitor
  int cyc = 0, nbytes = 0, data_err = 0, addr_err = 0, cs_falls = 0;
  int per_err = 0, mosi_err = 0, last_wr = -1, done_cyc = -1, last_rise = -1;
  logic p_sclk = 0, p_mosi = 0, p_cs = 1;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      nbytes = 0; data_err = 0; addr_err = 0; cs_falls = 0; per_err = 0;
      mosi_err = 0; last_wr = -1; done_cyc = -1; last_rise = -1;
    end else begin
      if (wr_valid) begin
        if (wr_addr != 17'(nbytes)) addr_err++;
        if (wr_data != pat(nbytes)) data_err++;
        nbytes++;
        last_wr = cyc;
      end
      if (done && done_cyc < 0) done_cyc = cyc;
      if (!spi_cs_n && p_cs) cs_falls++;
      if (!spi_cs_n) begin
        if (spi_sclk && !p_sclk) begin
          if (last_rise >= 0 && cyc - last_rise != DIV) per_err++;
          last_rise = cyc;
        end
        if (!spi_sclk && p_sclk && cyc - last_rise != DIV / 2) per_err++;
        if (!p_cs && spi_mosi != p_mosi && (spi_sclk || p_sclk)) mosi_err++;
      end else begin
        last_rise = -1;
        if (!done && spi_sclk) per_err++;
      end
    end
    p_sclk = spi_sclk; p_mosi = spi_mosi; p_cs = spi_cs_n;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int len, input bit en);
    @(negedge clk);
    rst_n = 0; img_len = 18'(len); led_mode_en = en; act_pulse = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    check(spi_cs_n && !spi_sclk && !done && !wr_valid, "R1 reset state",
          {spi_cs_n, spi_sclk, done, wr_valid}, 4'b1000);
  endtask

  task automatic t_load(input int len);
    do_reset(len, 0);
    wait_done(len * 8 * DIV + 40 * DIV);
    @(negedge clk);
    check(hdr == 32'h0300_0000, "R2 header", hdr, 32'h0300_0000);
    check(mosi_err == 0, "R3 mosi changes", mosi_err, 0);
    check(per_err == 0, "R4 sclk timing", per_err, 0);
    check(addr_err == 0 && data_err == 0, "R5 bytes", addr_err + data_err, 0);
    check(nbytes == len && cs_falls == 1, "R6 byte count", nbytes, len);
    check(done_cyc == last_wr + 1, "R6 done timing", done_cyc, last_wr + 1);
    repeat (100) @(negedge clk);
    check(done && spi_cs_n && cs_falls == 1, "R6 stays done",
          cs_falls, 1);
  endtask

  task automatic t_zero;
    do_reset(0, 0);
    repeat (20) @(negedge clk);
    check(done && cs_falls == 0 && nbytes == 0, "R7 zero length", cs_falls, 0);
  endtask

  task automatic t_led;
    do_reset(2, 1);
    wait_done(2000);
    @(negedge clk);
    check(spi_mosi && spi_sclk, "R8 lamps off", {spi_mosi, spi_sclk}, 3);
    act_pulse = 2'b10;
    for (int i = 1; i <= 32; i++) begin
      @(negedge clk);
      act_pulse = (i == 9) ? 2'b10 : 2'b00;
      if (i == 1) check(!spi_mosi && spi_sclk, "R8 ch3 on data pin",
                        {spi_mosi, spi_sclk}, 1);
      if (i == 29) check(!spi_mosi, "R9 retrigger held", spi_mosi, 0);
      if (i == 30) check(spi_mosi, "R9 retrigger end", spi_mosi, 1);
    end
    act_pulse = 2'b01;
    for (int i = 1; i <= 22; i++) begin
      @(negedge clk);
      act_pulse = 2'b00;
      if (i == 1) check(!spi_sclk && spi_mosi, "R8 ch2 on clock pin",
                        {spi_mosi, spi_sclk}, 2);
      if (i == 20) check(!spi_sclk, "R9 last lit cycle", spi_sclk, 0);
      if (i == 21) check(spi_sclk, "R9 stretch ends", spi_sclk, 1);
    end
  endtask

  task automatic t_blocked;
    do_reset(40, 1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      act_pulse = (i % 7 == 0) ? 2'b11 : 2'b00;
    end
    act_pulse = 2'b00;
    wait_done(4000);
    @(negedge clk);
    check(per_err == 0 && mosi_err == 0 && data_err == 0 && nbytes == 40,
          "R10 pulses ignored before done", per_err + mosi_err + data_err, 0);
    repeat (STR + 2) @(negedge clk);
    check(spi_sclk && spi_mosi, "R10 no stale lamp", {spi_mosi, spi_sclk}, 3);
    do_reset(3, 0);
    wait_done(2000);
    act_pulse = 2'b11;
    @(negedge clk); act_pulse = 2'b00;
    @(negedge clk);
    check(!spi_sclk && !spi_mosi, "R10 led mode off", {spi_mosi, spi_sclk}, 0);
  endtask

  initial begin
    t_reset();
    t_load(1);
    t_load(3);
    t_load(300);
    t_zero();
    t_led();
    t_blocked();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    nchk++; nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule